// File: doc/BRIEF.md
# Dual-Port Linked-Load / Conditional-Store Reservation Monitor

Two requesters share one small word memory held inside this block. Each requester issues four kinds of access: a plain load, a plain store, a linked load and a conditional store. A linked load returns the memory word and leaves a reservation on that word for the issuing port. A conditional store from the same port writes memory only if the reservation is still intact. It reports 1 when it writes and 0 when it is refused, so software can build an atomic exchange by retrying until it reads 1.

Every write from either port is compared against both ports' reservations. A write to a reserved word cancels the reservation, so a conditional store fails after the other side has touched the location. Requests arrive on a valid/ready handshake, one access per cycle. Each accepted request returns exactly one response on the next cycle. Responses are not back-pressured, so a requester must always be able to take them.

Top module: `llsc_monitor`

## Requirements
- R1: The access address is the base operand plus the 16-bit offset sign-extended to the address width. Bits [1:0] select a byte within a word. The memory word index is bits [2 +: log2(DEPTH)], and a reservation keeps the full word address (address shifted right by 2).
- R2: The operation code is 0 for a plain load, 1 for a plain store, 2 for a linked load and 3 for a conditional store. A request accepted in cycle t produces a response on that port in cycle t+1, and in no other cycle. A load or linked load returns the word as it was before that cycle, and a plain store returns 0.
- R3: A linked load sets the issuing port's reservation to its word address, replacing any earlier reservation of that port.
- R4: A conditional store whose port holds a valid reservation on the same word address writes its data and returns 1.
- R5: A conditional store without a matching valid reservation returns 0 and leaves memory unchanged. This covers both the case of no reservation and the case of a reservation on a different word.
- R6: Any write to a word address, whether a plain store or a successful conditional store from either port, clears the reservation of every port on that address.
- R7: A conditional store consumes its own port's reservation whether it succeeds or fails, so an immediate second conditional store fails.
- R8: At most one request is accepted per cycle, and ready is asserted only for an accepted valid request. When both ports are valid, port 0 wins, unless port 1 was valid and refused in the previous cycle, in which case port 1 wins.
- R9: A refused request stays presented until accepted, and is then executed exactly as presented.
- R10: After reset the memory reads zero, no reservation is valid and no response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request accepted this cycle |
| p0_op | input | 2 | Port 0 operation code |
| p0_base | input | ADDR_W | Port 0 base address operand |
| p0_ofs | input | 16 | Port 0 signed offset |
| p0_wdata | input | DATA_W | Port 0 store data |
| p0_rvalid | output | 1 | Port 0 response valid |
| p0_rdata | output | DATA_W | Port 0 response data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request accepted this cycle |
| p1_op | input | 2 | Port 1 operation code |
| p1_base | input | ADDR_W | Port 1 base address operand |
| p1_ofs | input | 16 | Port 1 signed offset |
| p1_wdata | input | DATA_W | Port 1 store data |
| p1_rvalid | output | 1 | Port 1 response valid |
| p1_rdata | output | DATA_W | Port 1 response data |

## Verification
The bench builds the block with its default parameters: 32-bit data and addresses and a 16-word memory. The random addresses are drawn from about ten neighbouring words, including negative offsets, so the two ports keep colliding on reserved words. With this pool, stores from one port regularly land on the other port's reservation. Both ports are also often valid in the same cycle, which exercises the one-cycle hold of port 1.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } op_e;
endpackage

// File: rtl/llsc_arbiter.sv
// Two-way grant: port 0 normally wins, port 1 wins after one refusal.
module llsc_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] grant
);
  logic owed_q;

  always_comb begin
    grant[0] = req[0] & ~(req[1] & owed_q);
    grant[1] = req[1] & (~req[0] | owed_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= 1'b0;
    else        owed_q <= req[1] & ~grant[1];
  end
endmodule

// File: rtl/llsc_resv.sv
// One reservation slot: valid flag plus word address.
module llsc_resv #(
  parameter int WA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic            consume,
  input  logic [WA_W-1:0] set_wa,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_wa,
  output logic            held,
  output logic [WA_W-1:0] held_wa
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      held_wa <= '0;
    end else if (set) begin
      held    <= 1'b1;
      held_wa <= set_wa;
    end else if (consume || (wr_en && wr_wa == held_wa)) begin
      held    <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_mem.sv
// Word array: asynchronous read, synchronous write, cleared by reset.
module llsc_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];

  assign rdata = words[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[idx] <= wdata;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  output logic              p0_ready,
  input  logic [1:0]        p0_op,
  input  logic [ADDR_W-1:0] p0_base,
  input  logic [15:0]       p0_ofs,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_valid,
  output logic              p1_ready,
  input  logic [1:0]        p1_op,
  input  logic [ADDR_W-1:0] p1_base,
  input  logic [15:0]       p1_ofs,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata
);
  import llsc_pkg::*;

  localparam int NP    = 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LSB   = $clog2(DATA_W / 8);
  localparam int WA_W  = ADDR_W - LSB;

  logic [NP-1:0]             req_v, grant;
  logic [1:0]                req_op   [NP];
  logic [ADDR_W-1:0]         req_base [NP];
  logic [15:0]               req_ofs  [NP];
  logic [DATA_W-1:0]         req_wd   [NP];

  assign req_v       = {p1_valid, p0_valid};
  assign req_op[0]   = p0_op;    assign req_op[1]   = p1_op;
  assign req_base[0] = p0_base;  assign req_base[1] = p1_base;
  assign req_ofs[0]  = p0_ofs;   assign req_ofs[1]  = p1_ofs;
  assign req_wd[0]   = p0_wdata; assign req_wd[1]   = p1_wdata;

  llsc_arbiter u_arb (.clk(clk), .rst_n(rst_n), .req(req_v), .grant(grant));
  assign p0_ready = grant[0];
  assign p1_ready = grant[1];

  // selected request
  logic              acc, sel;
  op_e               sel_op;
  logic [ADDR_W-1:0] eff_addr;
  logic [WA_W-1:0]   acc_wa;
  logic [IDX_W-1:0]  acc_idx;

  assign acc      = |grant;
  assign sel      = grant[1];
  assign sel_op   = op_e'(req_op[sel]);
  assign eff_addr = req_base[sel] + {{(ADDR_W-16){req_ofs[sel][15]}}, req_ofs[sel]};
  assign acc_wa   = eff_addr[ADDR_W-1:LSB];
  assign acc_idx  = acc_wa[IDX_W-1:0];

  // reservations
  logic [NP-1:0]            res_v;
  logic [NP-1:0][WA_W-1:0]  res_wa;
  logic                     cond_ok, wr_en;
  logic [DATA_W-1:0]        mem_rd, rsp_val;

  assign cond_ok = acc && sel_op == OP_COND && res_v[sel] && res_wa[sel] == acc_wa;
  assign wr_en   = acc && (sel_op == OP_STORE || cond_ok);

  for (genvar g = 0; g < NP; g++) begin : g_resv
    llsc_resv #(.WA_W(WA_W)) u_resv (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (grant[g] && sel_op == OP_LINK),
      .consume (grant[g] && sel_op == OP_COND),
      .set_wa  (acc_wa),
      .wr_en   (wr_en),
      .wr_wa   (acc_wa),
      .held    (res_v[g]),
      .held_wa (res_wa[g])
    );
  end

  llsc_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(acc_idx),
    .wdata(req_wd[sel]), .rdata(mem_rd)
  );

  always_comb begin
    unique case (sel_op)
      OP_LOAD, OP_LINK: rsp_val = mem_rd;
      OP_COND:          rsp_val = DATA_W'(cond_ok);
      default:          rsp_val = '0;
    endcase
  end

  // responses, one cycle after acceptance
  logic [NP-1:0]     rv_q;
  logic [DATA_W-1:0] rd_q [NP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= '0;
      for (int i = 0; i < NP; i++) rd_q[i] <= '0;
    end else begin
      rv_q <= grant;
      if (acc) rd_q[sel] <= rsp_val;
    end
  end

  assign p0_rvalid = rv_q[0];
  assign p1_rvalid = rv_q[1];
  assign p0_rdata  = rd_q[0];
  assign p1_rdata  = rd_q[1];
endmodule

// File: rtl/llsc_monitor_sva.sv
module llsc_monitor_sva #(
  parameter int DATA_W = 32,
  parameter int WA_W   = 30
) (
  input logic                clk,
  input logic                rst_n,
  input logic                p0_valid,
  input logic                p0_ready,
  input logic [1:0]          p0_op,
  input logic                p1_valid,
  input logic                p1_ready,
  input logic [1:0]          p1_op,
  input logic                p0_rvalid,
  input logic [DATA_W-1:0]   p0_rdata,
  input logic                p1_rvalid,
  input logic [DATA_W-1:0]   p1_rdata,
  input logic                wr_en,
  input logic [WA_W-1:0]     wr_wa,
  input logic [1:0]          res_v,
  input logic [1:0][WA_W-1:0] res_wa
);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_ready, p0_ready}) && (!p0_ready || p0_valid) && (!p1_ready || p1_valid));

  assert_p1_not_starved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_valid && !p1_ready) |=> (!p1_valid || p1_ready));

  assert_p0_only_loses_to_p1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p0_ready) |-> p1_ready);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    p0_ready |=> p0_rvalid);

  assert_rsp_only_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_ready |=> !p1_rvalid);

  assert_cond_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready && p0_op == 2'd3) |=> (p0_rdata <= DATA_W'(1)));

  assert_cond_needs_resv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_ready && p1_op == 2'd3 && !res_v[1]) |=> (p1_rdata == '0));

  assert_write_clears_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && res_v[0] && res_wa[0] == wr_wa) |=> !res_v[0]);

  assert_write_clears_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && res_v[1] && res_wa[1] == wr_wa) |=> !res_v[1]);

  assert_cond_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready && p0_op == 2'd3) |=> !res_v[0]);
endmodule

bind llsc_monitor llsc_monitor_sva #(.DATA_W(DATA_W), .WA_W(WA_W)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_op(p0_op),
  .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_op(p1_op),
  .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
  .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
  .wr_en(wr_en), .wr_wa(acc_wa), .res_v(res_v), .res_wa(res_wa)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv [2];
  logic [1:0]  pop [2];
  logic [31:0] pb [2];
  logic [15:0] po [2];
  logic [31:0] pw [2];
  logic        rdy0, rdy1, rv0, rv1;
  logic [31:0] rd0, rd1;

  always #4 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(pv[0]), .p0_ready(rdy0), .p0_op(pop[0]), .p0_base(pb[0]),
    .p0_ofs(po[0]), .p0_wdata(pw[0]), .p0_rvalid(rv0), .p0_rdata(rd0),
    .p1_valid(pv[1]), .p1_ready(rdy1), .p1_op(pop[1]), .p1_base(pb[1]),
    .p1_ofs(po[1]), .p1_wdata(pw[1]), .p1_rvalid(rv1), .p1_rdata(rd1)
  );

  // reference model
  logic [31:0] mmem [DEPTH];
  bit          mres [2];
  logic [29:0] mwa [2];
  bit          owed;
  bit          ev [2];
  logic [31:0] ed [2];
  string       etag [2];
  string       ctx = "";
  bit          accd [2];
  int          checks = 0, fails = 0;

  function automatic logic [29:0] wa_of(logic [31:0] b, logic [15:0] o);
    logic [31:0] a;
    a = b + {{16{o[15]}}, o};   // R1 address forming
    return a[31:2];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s%s actual=%h expected=%h at %0t", ctx, tag, act, exp, $time);
    end
  endtask

  task automatic apply(int p);
    logic [29:0] wa;
    int          ix;
    bit          ok;
    wa = wa_of(pb[p], po[p]);
    ix = int'(wa[3:0]);
    ev[p] = 1'b1;
    case (pop[p])
      2'd0: begin ed[p] = mmem[ix]; etag[p] = "R2 load data"; end
      2'd1: begin
        mmem[ix] = pw[p]; ed[p] = '0; etag[p] = "R2 store ack";
        for (int q = 0; q < 2; q++) if (mres[q] && mwa[q] == wa) mres[q] = 0;
      end
      2'd2: begin
        ed[p] = mmem[ix]; mres[p] = 1; mwa[p] = wa; etag[p] = "R3 linked load";
      end
      default: begin
        ok = mres[p] && mwa[p] == wa;
        mres[p] = 0;
        ed[p] = {31'd0, ok};
        etag[p] = ok ? "R4 cond pass" : "R5 cond fail";
        if (ok) begin
          mmem[ix] = pw[p];
          for (int q = 0; q < 2; q++) if (mres[q] && mwa[q] == wa) mres[q] = 0;
        end
      end
    endcase
  endtask

  // one clock: inputs already set by caller at the falling edge
  task automatic cycle();
    bit g0, g1;
    #1;
    g0 = pv[0] && !(pv[1] && owed);
    g1 = pv[1] && (!pv[0] || owed);
    chk("R8 grant", {30'd0, rdy1, rdy0}, {30'd0, g1, g0});
    owed = pv[1] && !g1;
    ev[0] = 0; ev[1] = 0;
    accd[0] = g0; accd[1] = g1;
    if (g0) apply(0);
    if (g1) apply(1);
    @(negedge clk);
    if (g0) pv[0] = 0;   // R9: refused requests stay untouched
    if (g1) pv[1] = 0;
    chk("R2 rvalid p0", {31'd0, rv0}, {31'd0, ev[0]});
    chk("R2 rvalid p1", {31'd0, rv1}, {31'd0, ev[1]});
    if (ev[0]) chk({etag[0], " p0"}, rd0, ed[0]);
    if (ev[1]) chk({etag[1], " p1"}, rd1, ed[1]);
  endtask

  task automatic setreq(int p, logic [1:0] op, logic [31:0] b, logic [15:0] o, logic [31:0] w);
    pv[p] = 1; pop[p] = op; pb[p] = b; po[p] = o; pw[p] = w;
  endtask

  task automatic issue(int p, logic [1:0] op, int wix, logic [31:0] w);
    setreq(p, op, 32'h1000, 16'(wix * 4), w);
    for (int k = 0; k < 5; k++) begin
      cycle();
      if (accd[p]) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 2; p++) begin
      pv[p] = 0; pop[p] = 0; pb[p] = 0; po[p] = 0; pw[p] = 0;
      mres[p] = 0; mwa[p] = 0;
    end
    for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
    owed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ctx = "R10 ";
    chk("reset rvalid", {30'd0, rv1, rv0}, 32'd0);
    chk("reset ready", {30'd0, rdy1, rdy0}, 32'd0);
    issue(0, 2'd0, 5, 0);                   // memory cleared
    issue(1, 2'd3, 5, 32'h55);              // no reservation after reset

    ctx = "R1 ";                            // negative offset: 0x1010 - 8 -> word 2
    setreq(0, 2'd1, 32'h1010, 16'hFFF8, 32'hA5);
    cycle();
    issue(1, 2'd0, 2, 0);

    ctx = "R4 ";
    issue(0, 2'd2, 3, 0);
    issue(0, 2'd3, 3, 32'h11);
    issue(1, 2'd0, 3, 0);

    ctx = "R6 ";                            // swap loop broken by the other port
    issue(0, 2'd2, 4, 0);
    issue(1, 2'd1, 4, 32'h22);
    issue(0, 2'd3, 4, 32'h33);
    issue(1, 2'd0, 4, 0);
    issue(0, 2'd2, 4, 0);
    issue(0, 2'd3, 4, 32'h33);
    issue(1, 2'd0, 4, 0);

    ctx = "R7 ";
    issue(1, 2'd2, 5, 0);
    issue(1, 2'd3, 5, 32'h44);
    issue(1, 2'd3, 5, 32'h45);
    issue(0, 2'd0, 5, 0);

    ctx = "R5 ";
    issue(0, 2'd3, 6, 32'h77);
    issue(0, 2'd0, 6, 0);
    issue(0, 2'd2, 7, 0);
    issue(0, 2'd3, 8, 32'h88);
    issue(1, 2'd0, 8, 0);

    ctx = "R3 ";
    issue(1, 2'd2, 9, 0);
    issue(1, 2'd2, 10, 0);
    issue(1, 2'd3, 9, 32'h99);

    ctx = "R8 ";
    setreq(0, 2'd0, 32'h1000, 16'd12, 0);
    setreq(1, 2'd0, 32'h1000, 16'd16, 0);
    cycle();
    setreq(0, 2'd0, 32'h1000, 16'd20, 0);
    cycle();
    cycle();

    ctx = "rand ";
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        if (!pv[p] && ($urandom % 100) < 65)
          setreq(p, 2'($urandom % 4), 32'h1000 + (($urandom % 4) << 2),
                 16'(int'($urandom % 8) * 4 - 8), $urandom);
      end
      cycle();
    end
    for (int k = 0; k < 4 && (pv[0] || pv[1]); k++) cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule